// File: doc/BRIEF.md
# Machine Cycle and State Timing Generator

This block paces a small 8-bit processor that runs from a single clock. Each clock period is one state. States are grouped into machine cycles of three to five states, and one to five machine cycles make up an instruction. The block counts the current machine cycle (M1..M5) and state (T1..T5). It raises a one-clock start pulse at the beginning of every machine cycle that reaches the bus. It marks machine cycles that do no bus work, such as the two middle cycles of a register-pair double add, and it suppresses the start pulse in those cycles.

The instruction decoder supplies a profile for the instruction, made of three parts: a number of machine cycles, a state count for each machine cycle and a mask of internal-only cycles. The M1 length and the cycle count are read live while M1 runs, because the opcode fetch is still in progress. At the final state of M1 the whole profile is captured and used for the rest of the instruction.

Three kinds of state have no fixed length, although each still lasts a whole number of clocks. A low ready line stretches an external cycle with wait states after T2. A bus hold request parks the processor between machine cycles and is acknowledged. A halt request parks the processor between instructions. A typical opcode fetch is 4 states; a memory-indirect add is 2 cycles and 7 states in total; a register-pair store to a direct address is 5 cycles.

Top module: `cpu_cycle_timer`

## Requirements
- R1: While reset is low and on the first clock after its release, the outputs show M1 T1, the start pulse is high, and the wait, hold-acknowledge, halt and internal flags are low.
- R2: The state number rises by one per clock. A machine cycle ends at its programmed length, then the next cycle begins at T1. Field k-1 of prof_len (3 bits at [3k-1:3k-3]) gives the length of Mk. M1 is clamped to 4..5 and the other cycles to 3..5.
- R3: prof_mcount, clamped to 1..5, sets the number of machine cycles. After the last state of the last cycle, the next clock is M1 T1 of a new instruction.
- R4: sync is high for exactly the T1 clock of every machine cycle that is not internal, and low in every other clock.
- R5: prof_int bit j marks machine cycle M(j+1) as internal; M1 is never internal. In an internal cycle, int_cyc is high throughout, sync stays low and ready is ignored (no wait state).
- R6: In T2 of an external cycle, a low ready makes the next clock a wait state. In a wait state t_num stays 2 and wait_st is high. The clock after ready is seen high is T3.
- R7: hold is sampled only in the last state of a machine cycle. If it is high, hlda is high from the next clock, with m_num and t_num both 0. The clock after hold is seen low is T1 of the following machine cycle.
- R8: A high halt_req in the last state of the last machine cycle makes the next clock a halt state: halt_st is high, and m_num and t_num are 0. The clock after halt_req is seen low is M1 T1.
- R9: A high hold during a halt state gives hold acknowledge from the next clock. When hold is released, the halt state resumes if halt_req is still high; otherwise the next clock is M1 T1.
- R10: If hold and halt_req are both high in the last state of an instruction, the hold is served first and the halt state follows it.
- R11: The cycle count, the lengths of M2..M5 and the internal mask are captured at the final state of M1. Later changes on those inputs have no effect until the next instruction's M1 ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period per state |
| rst_n | input | 1 | Active-low synchronous reset |
| prof_len | input | 15 | Per-cycle state counts, field k-1 for Mk |
| prof_mcount | input | 3 | Machine cycles in the instruction |
| prof_int | input | 4 | Internal-cycle mask, bit j for M(j+1) |
| ready | input | 1 | High when the addressed device can complete |
| hold | input | 1 | Bus hold request |
| halt_req | input | 1 | Request to stop after the instruction |
| m_num | output | 3 | Current machine cycle, 0 while parked |
| t_num | output | 3 | Current state, 0 while parked |
| sync | output | 1 | Start pulse of an external machine cycle |
| wait_st | output | 1 | Wait state in progress |
| hlda | output | 1 | Hold acknowledge |
| halt_st | output | 1 | Halt state in progress |
| int_cyc | output | 1 | Current machine cycle is internal |

## Verification
Hold and halt can both fall on the last state of an instruction. The bench raises both in that same state and expects the hold acknowledge first, then the halt state, then M1 T1 only after halt_req drops. The bench also raises hold while the block sits in a halt state. It checks that the acknowledge replaces the halt and that the halt state returns after the release, including the case where halt_req drops in the very clock the hold is raised. Low ready inside internal cycles is used to show that a wait cannot coincide with an internal cycle.

// File: rtl/ccg_pkg.sv
package ccg_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_WAIT = 2'd1,
    MODE_HOLD = 2'd2,
    MODE_HALT = 2'd3
  } ccg_mode_e;

  // Bound a requested count into an allowed range.
  function automatic int ccg_clamp(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/ccg_profile.sv
module ccg_profile
  import ccg_pkg::*;
#(
  parameter int MAX_M     = 5,
  parameter int MAX_T     = 5,
  parameter int MIN_T     = 3,
  parameter int FETCH_MIN = 4,
  localparam int MW = $clog2(MAX_M + 1),
  localparam int TW = $clog2(MAX_T + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  latch_en,
  input  logic [MW-1:0]         cur_m,
  input  logic [MAX_M*TW-1:0]   prof_len,
  input  logic [MW-1:0]         prof_mcount,
  input  logic [MAX_M-1:1]      prof_int,
  output logic [TW-1:0]         cur_len,
  output logic                  cur_int,
  output logic                  cur_last
);

  logic [TW-1:0]    live_len [MAX_M];
  logic [TW-1:0]    held_len [MAX_M];
  logic [MAX_M-1:0] held_int;
  logic [MW-1:0]    live_mc;
  logic [MW-1:0]    held_mc;
  logic [MW-1:0]    idx;

  // Clamp each cycle field; the fetch cycle has its own lower bound.
  for (genvar g = 0; g < MAX_M; g++) begin : g_len
    localparam int LO = (g == 0) ? FETCH_MIN : MIN_T;
    assign live_len[g] = TW'(ccg_clamp(int'(prof_len[g*TW +: TW]), LO, MAX_T));
  end

  assign live_mc = MW'(ccg_clamp(int'(prof_mcount), 1, MAX_M));
  assign idx     = cur_m - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_M; i++) held_len[i] <= TW'(MIN_T);
      held_int <= '0;
      held_mc  <= MW'(1);
    end else if (latch_en) begin
      for (int i = 0; i < MAX_M; i++) held_len[i] <= live_len[i];
      held_int <= {prof_int, 1'b0};
      held_mc  <= live_mc;
    end
  end

  // M1 reads the decoder live; later cycles read the captured profile.
  always_comb begin
    if (cur_m <= MW'(1)) begin
      cur_len  = live_len[0];
      cur_int  = 1'b0;
      cur_last = (live_mc == MW'(1));
    end else begin
      cur_len  = held_len[idx];
      cur_int  = held_int[idx];
      cur_last = (cur_m >= held_mc);
    end
  end

endmodule

// File: rtl/ccg_sequencer.sv
module ccg_sequencer
  import ccg_pkg::*;
#(
  parameter int MAX_M = 5,
  parameter int MAX_T = 5,
  localparam int MW = $clog2(MAX_M + 1),
  localparam int TW = $clog2(MAX_T + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ready,
  input  logic          hold,
  input  logic          halt_req,
  input  logic [TW-1:0] cur_len,
  input  logic          cur_int,
  input  logic          cur_last,
  output ccg_mode_e     mode_q,
  output logic [MW-1:0] m_q,
  output logic [TW-1:0] t_q,
  output logic          cyc_end,
  output logic          wait_enter,
  output logic          latch_m1
);

  ccg_mode_e     mode_d;
  logic [MW-1:0] m_d, next_m;
  logic [TW-1:0] t_d;
  logic          pend_q, pend_d;

  always_comb begin
    cyc_end    = (mode_q == MODE_RUN) && (t_q >= cur_len);
    wait_enter = (mode_q == MODE_RUN) && (t_q == TW'(2)) && !cur_int && !ready;
    next_m     = cur_last ? MW'(1) : m_q + 1'b1;
    latch_m1   = cyc_end && (m_q == MW'(1));
  end

  always_comb begin
    mode_d = mode_q;
    m_d    = m_q;
    t_d    = t_q;
    pend_d = pend_q;
    unique case (mode_q)
      MODE_RUN: begin
        if (wait_enter) begin
          mode_d = MODE_WAIT;
        end else if (cyc_end) begin
          if (hold) begin
            mode_d = MODE_HOLD;
            m_d    = next_m;
            t_d    = '0;
            pend_d = cur_last && halt_req;
          end else if (cur_last && halt_req) begin
            mode_d = MODE_HALT;
            m_d    = MW'(1);
            t_d    = '0;
          end else begin
            m_d = next_m;
            t_d = TW'(1);
          end
        end else begin
          t_d = t_q + 1'b1;
        end
      end
      MODE_WAIT: begin
        if (ready) begin
          mode_d = MODE_RUN;
          t_d    = TW'(3);
        end
      end
      MODE_HOLD: begin
        if (!hold) begin
          pend_d = 1'b0;
          if (pend_q && halt_req) begin
            mode_d = MODE_HALT;
          end else begin
            mode_d = MODE_RUN;
            t_d    = TW'(1);
          end
        end
      end
      MODE_HALT: begin
        if (hold) begin
          mode_d = MODE_HOLD;
          pend_d = 1'b1;
        end else if (!halt_req) begin
          mode_d = MODE_RUN;
          m_d    = MW'(1);
          t_d    = TW'(1);
        end
      end
      default: mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_RUN;
      m_q    <= MW'(1);
      t_q    <= TW'(1);
      pend_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      m_q    <= m_d;
      t_q    <= t_d;
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/ccg_status.sv
module ccg_status
  import ccg_pkg::*;
#(
  parameter int MAX_M = 5,
  parameter int MAX_T = 5,
  localparam int MW = $clog2(MAX_M + 1),
  localparam int TW = $clog2(MAX_T + 1)
) (
  input  ccg_mode_e     mode_q,
  input  logic [MW-1:0] m_q,
  input  logic [TW-1:0] t_q,
  input  logic          cur_int,
  output logic [MW-1:0] m_num,
  output logic [TW-1:0] t_num,
  output logic          sync,
  output logic          wait_st,
  output logic          hlda,
  output logic          halt_st,
  output logic          int_cyc
);

  logic active;

  always_comb begin
    active  = (mode_q == MODE_RUN) || (mode_q == MODE_WAIT);
    m_num   = active ? m_q : '0;
    t_num   = active ? t_q : '0;
    sync    = (mode_q == MODE_RUN) && (t_q == TW'(1)) && !cur_int;
    wait_st = (mode_q == MODE_WAIT);
    hlda    = (mode_q == MODE_HOLD);
    halt_st = (mode_q == MODE_HALT);
    int_cyc = (mode_q == MODE_RUN) && cur_int;
  end

endmodule

// File: rtl/cpu_cycle_timer.sv
module cpu_cycle_timer
  import ccg_pkg::*;
#(
  parameter int MAX_M     = 5,
  parameter int MAX_T     = 5,
  parameter int MIN_T     = 3,
  parameter int FETCH_MIN = 4,
  localparam int MW = $clog2(MAX_M + 1),
  localparam int TW = $clog2(MAX_T + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [MAX_M*TW-1:0] prof_len,
  input  logic [MW-1:0]       prof_mcount,
  input  logic [MAX_M-1:1]    prof_int,
  input  logic                ready,
  input  logic                hold,
  input  logic                halt_req,
  output logic [MW-1:0]       m_num,
  output logic [TW-1:0]       t_num,
  output logic                sync,
  output logic                wait_st,
  output logic                hlda,
  output logic                halt_st,
  output logic                int_cyc
);

  ccg_mode_e     mode_q;
  logic [MW-1:0] m_q;
  logic [TW-1:0] t_q;
  logic [TW-1:0] cur_len;
  logic          cur_int, cur_last;
  logic          cyc_end, wait_enter, latch_m1;

  ccg_profile #(
    .MAX_M(MAX_M), .MAX_T(MAX_T), .MIN_T(MIN_T), .FETCH_MIN(FETCH_MIN)
  ) u_profile (
    .clk        (clk),
    .rst_n      (rst_n),
    .latch_en   (latch_m1),
    .cur_m      (m_q),
    .prof_len   (prof_len),
    .prof_mcount(prof_mcount),
    .prof_int   (prof_int),
    .cur_len    (cur_len),
    .cur_int    (cur_int),
    .cur_last   (cur_last)
  );

  ccg_sequencer #(.MAX_M(MAX_M), .MAX_T(MAX_T)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ready     (ready),
    .hold      (hold),
    .halt_req  (halt_req),
    .cur_len   (cur_len),
    .cur_int   (cur_int),
    .cur_last  (cur_last),
    .mode_q    (mode_q),
    .m_q       (m_q),
    .t_q       (t_q),
    .cyc_end   (cyc_end),
    .wait_enter(wait_enter),
    .latch_m1  (latch_m1)
  );

  ccg_status #(.MAX_M(MAX_M), .MAX_T(MAX_T)) u_status (
    .mode_q (mode_q),
    .m_q    (m_q),
    .t_q    (t_q),
    .cur_int(cur_int),
    .m_num  (m_num),
    .t_num  (t_num),
    .sync   (sync),
    .wait_st(wait_st),
    .hlda   (hlda),
    .halt_st(halt_st),
    .int_cyc(int_cyc)
  );

endmodule

// File: rtl/ccg_checker.sv
module ccg_checker #(
  parameter int MAX_M = 5,
  parameter int MAX_T = 5,
  localparam int MW = $clog2(MAX_M + 1),
  localparam int TW = $clog2(MAX_T + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ready,
  input logic          hold,
  input logic          halt_req,
  input logic [MW-1:0] m_num,
  input logic [TW-1:0] t_num,
  input logic          sync,
  input logic          wait_st,
  input logic          hlda,
  input logic          halt_st,
  input logic          int_cyc,
  input logic          cyc_end,
  input logic          wait_enter
);

  assert_park_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wait_st, hlda, halt_st}));

  assert_state_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (t_num != '0 && !cyc_end && !wait_enter && !wait_st) |=> t_num == $past(t_num) + 1'b1);

  assert_cycle_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end && !hold && !halt_req) |=> (t_num == TW'(1) && !hlda && !halt_st));

  assert_sync_t1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sync |-> (t_num == TW'(1) && !hlda && !halt_st && !wait_st));

  assert_internal_nowait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (int_cyc && t_num == TW'(2)) |=> !wait_st);

  assert_wait_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wait_st) |-> ($past(t_num) == TW'(2) && !$past(ready)));

  assert_wait_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_st && ready) |=> (!wait_st && t_num == TW'(3)));

  assert_hlda_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda) |-> ($past(hold) && ($past(cyc_end) || $past(halt_st))));

  assert_hlda_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hlda && !hold) |=> !hlda);

  assert_hlda_parked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> (m_num == '0 && t_num == '0));

  assert_halt_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_st) |-> $past(halt_req));

  assert_hold_in_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_st && hold) |=> hlda);

endmodule

bind cpu_cycle_timer ccg_checker #(.MAX_M(MAX_M), .MAX_T(MAX_T)) u_ccg_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ready     (ready),
  .hold      (hold),
  .halt_req  (halt_req),
  .m_num     (m_num),
  .t_num     (t_num),
  .sync      (sync),
  .wait_st   (wait_st),
  .hlda      (hlda),
  .halt_st   (halt_st),
  .int_cyc   (int_cyc),
  .cyc_end   (cyc_end),
  .wait_enter(wait_enter)
);

// File: tb/cpu_cycle_timer_test.sv
`timescale 1ns/1ps
module cpu_cycle_timer_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [14:0] prof_len;
  logic [2:0]  prof_mcount;
  logic [4:1]  prof_int;
  logic        ready, hold, halt_req;
  logic [2:0]  m_num, t_num;
  logic        sync, wait_st, hlda, halt_st, int_cyc;

  int  nchecks = 0;
  int  nerrors = 0;
  bit  done    = 1'b0;

  always #2 clk = ~clk;

  cpu_cycle_timer uut (
    .clk(clk), .rst_n(rst_n), .prof_len(prof_len), .prof_mcount(prof_mcount),
    .prof_int(prof_int), .ready(ready), .hold(hold), .halt_req(halt_req),
    .m_num(m_num), .t_num(t_num), .sync(sync), .wait_st(wait_st),
    .hlda(hlda), .halt_st(halt_st), .int_cyc(int_cyc)
  );

  function automatic int lim(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  function automatic int pk(int m, int t, int s, int i, int w, int h, int hl);
    return (m << 8) | (t << 5) | (s << 4) | (i << 3) | (w << 2) | (h << 1) | hl;
  endfunction

  task automatic check_state(string tag, int m, int t, bit s, bit i, bit w, bit h, bit hl);
    int exp_v, act_v;
    exp_v = pk(m, t, s, i, w, h, hl);
    act_v = pk(m_num, t_num, sync, int_cyc, wait_st, hlda, halt_st);
    nchecks++;
    if (act_v !== exp_v) begin
      nerrors++;
      $display("FAIL %s: actual m%0d t%0d s%0d i%0d w%0d h%0d halt%0d (%h) expected %h",
               tag, m_num, t_num, sync, int_cyc, wait_st, hlda, halt_st, act_v, exp_v);
    end
  endtask

  task automatic drive_profile(int mc, int l1, int l2, int l3, int l4, int l5, logic [4:0] mask);
    prof_len    = {3'(l5), 3'(l4), 3'(l3), 3'(l2), 3'(l1)};
    prof_mcount = 3'(mc);
    prof_int    = mask[4:1];
  endtask

  // Walks one instruction starting at its M1 T1 negedge; ends at the next instruction's M1 T1.
  task automatic run_instr(int mc, int l1, int l2, int l3, int l4, int l5, logic [4:0] mask,
                           int waits, int hold_at, int hold_n, int halt_n, int hih_n);
    int    lv[5];
    int    mce, len;
    bit    intc;
    string tag;
    lv  = '{l1, l2, l3, l4, l5};
    mce = lim(mc, 1, 5);
    for (int k = 1; k <= mce; k++) begin
      len  = (k == 1) ? lim(lv[0], 4, 5) : lim(lv[k-1], 3, 5);
      intc = (k > 1) && mask[k-1];
      for (int t = 1; t <= len; t++) begin
        tag = intc ? "R5" : ((k == 1 && t == 1) ? "R3" : ((t == 1) ? "R4" : ((k > 1) ? "R11" : "R2")));
        check_state(tag, k, t, (t == 1) && !intc, intc, 1'b0, 1'b0, 1'b0);
        ready = 1'b1;
        if (k == 1 && t == 1) drive_profile(mc, l1, l2, l3, l4, l5, mask);
        if (k == 2 && t == 1) begin
          // R11: scrambled decoder outputs after M1 must not matter
          prof_len    = '0;
          prof_mcount = ~prof_mcount;
          prof_int    = ~prof_int;
        end
        if (t == len) begin
          if (hold_at == k) hold = 1'b1;
          if (k == mce && halt_n > 0) halt_req = 1'b1;
        end
        if (t == 2 && waits > 0) begin
          ready = 1'b0;
          @(negedge clk);
          if (!intc) begin
            for (int w = 1; w <= waits; w++) begin
              check_state("R6", k, 2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
              if (w == waits) ready = 1'b1;
              @(negedge clk);
            end
          end
        end else begin
          @(negedge clk);
        end
      end
      if (hold_at == k) begin
        for (int i = 1; i <= hold_n; i++) begin
          check_state("R7", 0, 0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
          if (i == hold_n) hold = 1'b0;
          @(negedge clk);
        end
      end
    end
    if (halt_n > 0) begin
      for (int i = 1; i <= halt_n; i++) begin
        check_state((hold_at == mce) ? "R10" : "R8", 0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        if (i == halt_n) halt_req = 1'b0;
        if (i == 1 && hih_n > 0) begin
          hold = 1'b1;
          @(negedge clk);
          for (int j = 1; j <= hih_n; j++) begin
            check_state("R9", 0, 0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
            if (j == hih_n) hold = 1'b0;
            @(negedge clk);
          end
        end else begin
          @(negedge clk);
        end
      end
    end
  endtask

  initial begin
    rst_n    = 1'b0;
    ready    = 1'b1;
    hold     = 1'b0;
    halt_req = 1'b0;
    drive_profile(1, 4, 3, 3, 3, 3, 5'b0);
    repeat (2) @(negedge clk);
    check_state("R1", 1, 1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    check_state("R1", 1, 1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);

    // Sweep of cycle counts, length patterns, internal masks and wait counts.
    for (int mc = 1; mc <= 5; mc++) begin
      for (int b = 3; b <= 5; b++) begin
        run_instr(mc, 4 + (b % 2), 3 + ((b + 2) % 3), 3 + ((b + 3) % 3),
                  3 + ((b + 4) % 3), 3 + ((b + 5) % 3),
                  5'((mc * 5 + b) & 5'b11110), b - 3, 0, 0, 0, 0);
      end
    end

    // R2/R3 clamping of out-of-range counts.
    run_instr(0, 2, 0, 0, 0, 0, 5'b0, 0, 0, 0, 0, 0);
    run_instr(7, 7, 0, 6, 7, 1, 5'b00100, 1, 0, 0, 0, 0);
    // Memory-indirect add shape: 2 cycles, 7 states.
    run_instr(2, 4, 3, 0, 0, 0, 5'b0, 0, 0, 0, 0, 0);
    // Double-add shape: middle cycles internal, low ready ignored there (R5).
    run_instr(3, 4, 3, 3, 0, 0, 5'b00110, 3, 0, 0, 0, 0);
    // Register-pair direct store shape: 5 cycles.
    run_instr(5, 4, 3, 3, 3, 3, 5'b0, 2, 0, 0, 0, 0);

    // R7 hold at various cycle ends.
    run_instr(3, 4, 3, 3, 0, 0, 5'b0, 0, 1, 3, 0, 0);
    run_instr(3, 5, 4, 3, 0, 0, 5'b0, 2, 2, 1, 0, 0);
    run_instr(3, 4, 3, 5, 0, 0, 5'b00010, 0, 3, 2, 0, 0);
    // R8 halt.
    run_instr(2, 4, 3, 0, 0, 0, 5'b0, 0, 0, 0, 4, 0);
    run_instr(1, 5, 0, 0, 0, 0, 5'b0, 0, 0, 0, 1, 0);
    // R10 hold and halt together.
    run_instr(2, 4, 4, 0, 0, 0, 5'b0, 0, 2, 2, 3, 0);
    run_instr(1, 4, 0, 0, 0, 0, 5'b0, 0, 1, 1, 2, 0);
    // R9 hold during halt.
    run_instr(1, 5, 0, 0, 0, 0, 5'b0, 0, 0, 0, 3, 2);
    run_instr(2, 4, 3, 0, 0, 0, 5'b0, 0, 0, 0, 1, 2);

    check_state("R3", 1, 1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchecks++;
      nerrors++;
      $display("FAIL watchdog: actual run still busy, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
      $finish;
    end
  end

endmodule